// File: doc/BRIEF.md
# Command Ring Consumer with Wrap-Bit Pointers

This block drains a sixteen-slot circular command ring that host software fills in memory. Each slot is sixteen bytes, read as two 64-bit words in one access. Software stores commands, then moves a producer pointer forward through a small register port. While its enable bit is set, the block fetches the slot under its consumer pointer, decodes the opcode and issues the matching action. Then it moves the consumer pointer forward. Software can read that pointer back, and the ring is drained once the two pointers are equal.

Both pointers carry one bit above the slot index. Equal indices with equal wrap bits mean the ring is empty. Equal indices with different wrap bits mean it is full. Because of this, all sixteen slots can be filled. The block has no caches. A configuration flush, an ASID-tagged TLB flush, a full TLB flush and a barrier each leave as a one-cycle pulse that carries the command's argument fields.

An opcode the block does not know stops the ring with an error flag. The consumer pointer stays on the faulting slot. Software can then repair the slot and acknowledge the error to restart.

Top module: `cmdq_consumer`

## Requirements
- R1: After reset the producer and consumer pointers are 0, the enable bit is 0, the error flag and every action pulse are low, no fetch is issued, and the base register reads back 4 in bits 4:0.
- R2: The base register (register select 0) keeps write bits ADDR_W-1:5, reads 0 above them, and always reads the ring-size log2 value 4 in bits 4:0. Slot k is fetched from byte address base + 16*k.
- R3: The producer pointer (select 1) and the consumer pointer (select 2) are 5 bits wide: index in bits 3:0, wrap in bit 4. The consumer advances by one modulo 32 per command, so the wrap bit toggles when the index passes 15.
- R4: With the pointers equal in all 5 bits, nothing is fetched. With equal indices and different wrap bits, `ring_full` is high, and all 16 slots are consumed in ring order.
- R5: Commands are fetched only while control register (select 3) bit 3 is 1. With it at 0, the consumer pointer holds and no action is issued.
- R6: Opcode 0x04 (bits 7:0 of word 0) pulses `cfg_inv_valid`, with `cfg_inv_range` taken from bits 4:0 of word 1.
- R7: Opcode 0x11 pulses `tlb_asid_valid`, with `tlb_asid` taken from bits 63:48 of word 0.
- R8: Opcode 0x30 pulses `tlb_all_valid`.
- R9: Opcode 0x46 pulses `sync_valid`, with `sync_cs` from word-0 bits 13:12, `sync_sh` from bits 23:22 and `sync_attr` from bits 27:24.
- R10: Any other opcode sets `cmd_err`, issues no action and leaves the consumer pointer on that slot. A control write with bit 7 set clears the error, and consumption resumes from that slot.
- R11: At most one command completes every two cycles: a fetch cycle, then an execute cycle. The action pulse lasts one cycle, and no two actions are ever high together.
- R12: A write to the consumer pointer takes effect only while control bit 3 is 0. While it is 1, the write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 2 | Write select: 0 base, 1 producer, 2 consumer, 3 control |
| reg_wr_data | input | 64 | Register write data |
| reg_rd_sel | input | 2 | Read select, same encoding |
| reg_rd_data | output | 64 | Register read data (combinational) |
| mem_req | output | 1 | Slot fetch request |
| mem_addr | output | ADDR_W | Byte address of the slot |
| mem_rdata | input | 128 | Slot contents, valid the cycle after `mem_req`; word 0 in bits 63:0 |
| ring_full | output | 1 | Equal indices, different wrap bits |
| cmd_err | output | 1 | Unknown opcode halted the ring |
| cfg_inv_valid | output | 1 | Configuration flush pulse |
| cfg_inv_range | output | 5 | Range field of that flush |
| tlb_asid_valid | output | 1 | ASID-tagged TLB flush pulse |
| tlb_asid | output | 16 | ASID of that flush |
| tlb_all_valid | output | 1 | Full TLB flush pulse |
| sync_valid | output | 1 | Barrier pulse |
| sync_cs | output | 2 | Completion-signal field |
| sync_sh | output | 2 | Shareability field |
| sync_attr | output | 4 | Attribute field |

## Verification
A consumer pointer that skips or repeats a slot shows up within two cycles. Either the wrong argument appears on an action pulse, or the read-back pointer disagrees with the producer once the ring should be drained. A wrap bit that toggles at the wrong time makes a full ring look empty, so nothing is fetched at all. The wrap test sees this as a missing run of sixteen actions. A stuck error flag, or one that clears too early, changes the pointer read back after the bad slot, and the watchdogged drain loop catches it.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
  localparam int ENTRY_BITS = 128;

  localparam logic [7:0] OP_CFG_ALL  = 8'h04;
  localparam logic [7:0] OP_TLB_ASID = 8'h11;
  localparam logic [7:0] OP_TLB_ALL  = 8'h30;
  localparam logic [7:0] OP_SYNC     = 8'h46;

  typedef enum logic [1:0] {
    SEL_BASE = 2'd0,
    SEL_PROD = 2'd1,
    SEL_CONS = 2'd2,
    SEL_CTRL = 2'd3
  } reg_sel_e;

  typedef enum logic { ST_FETCH = 1'b0, ST_EXEC = 1'b1 } eng_state_e;

  typedef struct packed {
    logic        cfg;
    logic        tlb_asid;
    logic        tlb_all;
    logic        sync;
    logic        bad;
    logic [4:0]  range;
    logic [15:0] asid;
    logic [1:0]  cs;
    logic [1:0]  sh;
    logic [3:0]  attr;
  } cmd_act_t;

  function automatic cmd_act_t decode_entry(input logic [ENTRY_BITS-1:0] e);
    cmd_act_t a;
    logic [63:0] w0;
    logic [63:0] w1;
    w0 = e[63:0];
    w1 = e[127:64];
    a = '0;
    a.range = w1[4:0];
    a.asid  = w0[63:48];
    a.cs    = w0[13:12];
    a.sh    = w0[23:22];
    a.attr  = w0[27:24];
    case (w0[7:0])
      OP_CFG_ALL:  a.cfg      = 1'b1;
      OP_TLB_ASID: a.tlb_asid = 1'b1;
      OP_TLB_ALL:  a.tlb_all  = 1'b1;
      OP_SYNC:     a.sync     = 1'b1;
      default:     a.bad      = 1'b1;
    endcase
    return a;
  endfunction
endpackage

// File: rtl/cmdq_regs.sv
module cmdq_regs
  import cmdq_pkg::*;
#(
  parameter int ADDR_W   = 48,
  parameter int IDX_W    = 4,
  parameter int BASE_LSB = 5,
  localparam int PTR_W   = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [63:0]       wr_data,
  input  logic [1:0]        rd_sel,
  input  logic [PTR_W-1:0]  cons,
  output logic [63:0]       rd_data,
  output logic [ADDR_W-1:0] base_addr,
  output logic [PTR_W-1:0]  prod,
  output logic              enable,
  output logic              ack,
  output logic              cons_wr,
  output logic [PTR_W-1:0]  cons_wdata
);
  localparam int HI_W = ADDR_W - BASE_LSB;

  logic [HI_W-1:0] base_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_hi <= '0;
      prod    <= '0;
      enable  <= 1'b0;
    end else if (wr_en) begin
      case (reg_sel_e'(wr_sel))
        SEL_BASE: base_hi <= wr_data[ADDR_W-1:BASE_LSB];
        SEL_PROD: prod    <= wr_data[PTR_W-1:0];
        SEL_CTRL: enable  <= wr_data[3];
        default: ;
      endcase
    end
  end

  assign base_addr  = {base_hi, {BASE_LSB{1'b0}}};
  assign ack        = wr_en && (reg_sel_e'(wr_sel) == SEL_CTRL) && wr_data[7];
  assign cons_wr    = wr_en && (reg_sel_e'(wr_sel) == SEL_CONS) && !enable;
  assign cons_wdata = wr_data[PTR_W-1:0];

  always_comb begin
    rd_data = '0;
    case (reg_sel_e'(rd_sel))
      SEL_BASE: begin
        rd_data[ADDR_W-1:BASE_LSB] = base_hi;
        rd_data[BASE_LSB-1:0]      = BASE_LSB'(IDX_W);
      end
      SEL_PROD: rd_data[PTR_W-1:0] = prod;
      SEL_CONS: rd_data[PTR_W-1:0] = cons;
      default:  rd_data[3]         = enable;
    endcase
  end
endmodule

// File: rtl/cmdq_decode.sv
module cmdq_decode
  import cmdq_pkg::*;
(
  input  logic [ENTRY_BITS-1:0] entry,
  output cmd_act_t              act
);
  assign act = decode_entry(entry);
endmodule

// File: rtl/cmdq_engine.sv
module cmdq_engine
  import cmdq_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int IDX_W  = 4,
  localparam int PTR_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              ack,
  input  logic              cons_wr,
  input  logic [PTR_W-1:0]  cons_wdata,
  input  logic [PTR_W-1:0]  prod,
  input  logic [ADDR_W-1:0] base_addr,
  input  cmd_act_t          act,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              exec_fire,
  output logic [PTR_W-1:0]  cons,
  output logic              err,
  output logic              ring_full
);
  localparam int OFF_W = $clog2(ENTRY_BITS / 8);

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return p + 1'b1;
  endfunction

  function automatic logic is_empty(input logic [PTR_W-1:0] c, input logic [PTR_W-1:0] p);
    return c == p;
  endfunction

  function automatic logic is_full(input logic [PTR_W-1:0] c, input logic [PTR_W-1:0] p);
    return (c[IDX_W-1:0] == p[IDX_W-1:0]) && (c[IDX_W] != p[IDX_W]);
  endfunction

  function automatic logic [ADDR_W-1:0] slot_addr(input logic [ADDR_W-1:0] b,
                                                  input logic [PTR_W-1:0] c);
    return b + (ADDR_W'(c[IDX_W-1:0]) << OFF_W);
  endfunction

  eng_state_e state;
  logic       has_work;
  logic       exec_bad;

  assign has_work  = enable && !err && !is_empty(cons, prod);
  assign mem_req   = (state == ST_FETCH) && has_work;
  assign mem_addr  = slot_addr(base_addr, cons);
  assign exec_fire = (state == ST_EXEC) && !act.bad;
  assign exec_bad  = (state == ST_EXEC) && act.bad;
  assign ring_full = is_full(cons, prod);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_FETCH;
      cons  <= '0;
      err   <= 1'b0;
    end else begin
      case (state)
        ST_FETCH: if (mem_req) state <= ST_EXEC;
        default:  state <= ST_FETCH;
      endcase
      if (cons_wr)        cons <= cons_wdata;
      else if (exec_fire) cons <= ptr_next(cons);
      if (exec_bad)       err <= 1'b1;
      else if (ack)       err <= 1'b0;
    end
  end

  a_r4_no_fetch_empty: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (cons != prod));
  a_r5_no_fetch_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> enable);
  a_r3_cons_step: assert property (@(posedge clk) disable iff (!rst_n)
    !cons_wr |=> (cons == $past(cons)) || (cons == ptr_next($past(cons))));
  a_r10_halt_on_err: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !ack && !cons_wr) |=> $stable(cons));
  a_r11_exec_after_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_EXEC) |-> $past(mem_req));
endmodule

// File: rtl/cmdq_action_out.sv
module cmdq_action_out
  import cmdq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fire,
  input  cmd_act_t    act,
  output logic        cfg_v,
  output logic [4:0]  range,
  output logic        asid_v,
  output logic [15:0] asid,
  output logic        all_v,
  output logic        sync_v,
  output logic [1:0]  cs,
  output logic [1:0]  sh,
  output logic [3:0]  attr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_v  <= 1'b0;
      asid_v <= 1'b0;
      all_v  <= 1'b0;
      sync_v <= 1'b0;
      range  <= '0;
      asid   <= '0;
      cs     <= '0;
      sh     <= '0;
      attr   <= '0;
    end else begin
      cfg_v  <= fire && act.cfg;
      asid_v <= fire && act.tlb_asid;
      all_v  <= fire && act.tlb_all;
      sync_v <= fire && act.sync;
      if (fire && act.cfg)      range <= act.range;
      if (fire && act.tlb_asid) asid  <= act.asid;
      if (fire && act.sync) begin
        cs   <= act.cs;
        sh   <= act.sh;
        attr <= act.attr;
      end
    end
  end

  a_r11_one_action: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cfg_v, asid_v, all_v, sync_v}));
  a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_v || asid_v || all_v || sync_v) |=> !(cfg_v || asid_v || all_v || sync_v));
endmodule

// File: rtl/cmdq_consumer.sv
module cmdq_consumer
  import cmdq_pkg::*;
#(
  parameter int ADDR_W   = 48,
  parameter int IDX_W    = 4,
  parameter int BASE_LSB = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_wr_en,
  input  logic [1:0]            reg_wr_sel,
  input  logic [63:0]           reg_wr_data,
  input  logic [1:0]            reg_rd_sel,
  output logic [63:0]           reg_rd_data,
  output logic                  mem_req,
  output logic [ADDR_W-1:0]     mem_addr,
  input  logic [ENTRY_BITS-1:0] mem_rdata,
  output logic                  ring_full,
  output logic                  cmd_err,
  output logic                  cfg_inv_valid,
  output logic [4:0]            cfg_inv_range,
  output logic                  tlb_asid_valid,
  output logic [15:0]           tlb_asid,
  output logic                  tlb_all_valid,
  output logic                  sync_valid,
  output logic [1:0]            sync_cs,
  output logic [1:0]            sync_sh,
  output logic [3:0]            sync_attr
);
  localparam int PTR_W = IDX_W + 1;

  logic [ADDR_W-1:0] base_addr;
  logic [PTR_W-1:0]  prod;
  logic [PTR_W-1:0]  cons;
  logic [PTR_W-1:0]  cons_wdata;
  logic              enable;
  logic              ack;
  logic              cons_wr;
  logic              exec_fire;
  cmd_act_t          act;

  cmdq_regs #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .BASE_LSB(BASE_LSB)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .wr_sel(reg_wr_sel),
    .wr_data(reg_wr_data), .rd_sel(reg_rd_sel), .cons(cons), .rd_data(reg_rd_data),
    .base_addr(base_addr), .prod(prod), .enable(enable), .ack(ack),
    .cons_wr(cons_wr), .cons_wdata(cons_wdata)
  );

  cmdq_decode u_decode (.entry(mem_rdata), .act(act));

  cmdq_engine #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_engine (
    .clk(clk), .rst_n(rst_n), .enable(enable), .ack(ack), .cons_wr(cons_wr),
    .cons_wdata(cons_wdata), .prod(prod), .base_addr(base_addr), .act(act),
    .mem_req(mem_req), .mem_addr(mem_addr), .exec_fire(exec_fire), .cons(cons),
    .err(cmd_err), .ring_full(ring_full)
  );

  cmdq_action_out u_out (
    .clk(clk), .rst_n(rst_n), .fire(exec_fire), .act(act),
    .cfg_v(cfg_inv_valid), .range(cfg_inv_range), .asid_v(tlb_asid_valid),
    .asid(tlb_asid), .all_v(tlb_all_valid), .sync_v(sync_valid),
    .cs(sync_cs), .sh(sync_sh), .attr(sync_attr)
  );
endmodule

// File: tb/cmdq_consumer_bench.sv
module cmdq_consumer_bench;
  localparam int AW = 48;
  localparam logic [63:0] BASE_WR  = 64'hABCD_1234_5678_9AFF;
  localparam logic [63:0] BASE_EXP = 64'h0000_1234_5678_9AE4;
  localparam logic [AW-1:0] BASE  = 48'h1234_5678_9AE0;

  logic clk = 0;
  logic rst_n = 0;
  logic reg_wr_en = 0;
  logic [1:0] reg_wr_sel = 0;
  logic [63:0] reg_wr_data = 0;
  logic [1:0] reg_rd_sel = 0;
  logic [63:0] reg_rd_data;
  logic mem_req;
  logic [AW-1:0] mem_addr;
  logic [127:0] mem_rdata = '0;
  logic ring_full, cmd_err, cfg_inv_valid, tlb_asid_valid, tlb_all_valid, sync_valid;
  logic [4:0] cfg_inv_range;
  logic [15:0] tlb_asid;
  logic [1:0] sync_cs, sync_sh;
  logic [3:0] sync_attr;

  cmdq_consumer u_cmdq_consumer (.*);

  always #5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, req_count = 0, addr_bad = 0, multi = 0;
  logic [127:0] ring [16];
  int ev_n = 0;
  int ev_kind [64];
  logic [63:0] ev_arg [64];
  int ev_cyc [64];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_req) begin
      req_count <= req_count + 1;
      if (mem_addr < BASE || mem_addr >= BASE + 256 || mem_addr[3:0] != 0)
        addr_bad <= addr_bad + 1;
      mem_rdata <= ring[4'((mem_addr - BASE) >> 4)];
    end
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual cycle %0d expected < 150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if ((32'(cfg_inv_valid) + 32'(tlb_asid_valid) + 32'(tlb_all_valid) + 32'(sync_valid)) > 1)
        multi++;
      if (ev_n < 64) begin
        if (cfg_inv_valid) begin ev_kind[ev_n] = 1; ev_arg[ev_n] = 64'(cfg_inv_range); ev_cyc[ev_n] = cyc; ev_n++; end
        else if (tlb_asid_valid) begin ev_kind[ev_n] = 2; ev_arg[ev_n] = 64'(tlb_asid); ev_cyc[ev_n] = cyc; ev_n++; end
        else if (tlb_all_valid) begin ev_kind[ev_n] = 3; ev_arg[ev_n] = 0; ev_cyc[ev_n] = cyc; ev_n++; end
        else if (sync_valid) begin ev_kind[ev_n] = 4; ev_arg[ev_n] = {56'b0, sync_cs, sync_sh, sync_attr}; ev_cyc[ev_n] = cyc; ev_n++; end
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [63:0] d);
    @(negedge clk);
    reg_wr_en = 1; reg_wr_sel = sel; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [63:0] d);
    @(negedge clk);
    reg_rd_sel = sel;
    #1 d = reg_rd_data;
  endtask

  task automatic wait_cons(input logic [63:0] target);
    logic [63:0] v;
    for (int i = 0; i < 200; i++) begin
      rd(2, v);
      if (v == target) return;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [127:0] c_cfg(input logic [4:0] r);
    return {59'b0, r, 56'b0, 8'h04};
  endfunction
  function automatic logic [127:0] c_asid(input logic [15:0] a);
    return {64'b0, a, 40'h0, 8'h11};
  endfunction
  function automatic logic [127:0] c_all();
    return {64'hFFFF, 56'b0, 8'h30};
  endfunction
  function automatic logic [127:0] c_sync(input logic [1:0] cs, input logic [1:0] sh, input logic [3:0] at);
    return {64'b0, 32'b0, 4'b0, at, sh, 8'b0, cs, 4'b0, 8'h46};
  endfunction

  task automatic t_reset();
    logic [63:0] v;
    rd(0, v); check(v == 64'h4, "R1 base reset", v, 4);
    rd(1, v); check(v == 0, "R1 prod reset", v, 0);
    rd(2, v); check(v == 0, "R1 cons reset", v, 0);
    rd(3, v); check(v == 0, "R1 ctrl reset", v, 0);
    check({cmd_err, mem_req, ring_full, cfg_inv_valid, tlb_asid_valid, tlb_all_valid, sync_valid} == 0,
          "R1 outputs idle", 64'({cmd_err, mem_req, ring_full}), 0);
  endtask

  task automatic t_base();
    logic [63:0] v;
    wr(0, BASE_WR);
    rd(0, v); check(v == BASE_EXP, "R2 base readback", v, BASE_EXP);
  endtask

  task automatic t_ops();
    logic [63:0] v;
    ring[0] = c_cfg(5'h1F); ring[1] = c_asid(16'hBEEF); ring[2] = c_all();
    ring[3] = c_sync(2'd2, 2'd3, 4'hF); ring[4] = c_cfg(5'h03);
    ev_n = 0;
    wr(3, 64'h8); wr(1, 64'd5);
    wait_cons(5); idle(4);
    rd(2, v); check(v == 5, "R3 cons after five", v, 5);
    check(ev_n == 5, "R11 five actions", 64'(ev_n), 5);
    check(ev_kind[0] == 1 && ev_arg[0] == 64'h1F, "R6 cfg range all", ev_arg[0], 64'h1F);
    check(ev_kind[1] == 2 && ev_arg[1] == 64'hBEEF, "R7 tlb asid", ev_arg[1], 64'hBEEF);
    check(ev_kind[2] == 3, "R8 tlb all", 64'(ev_kind[2]), 3);
    check(ev_kind[3] == 4 && ev_arg[3] == 64'hBF, "R9 sync fields", ev_arg[3], 64'hBF);
    check(ev_kind[4] == 1 && ev_arg[4] == 64'h03, "R6 cfg range 3", ev_arg[4], 64'h03);
    for (int i = 1; i < 5; i++)
      check(ev_cyc[i] - ev_cyc[i-1] == 2, "R11 two-cycle spacing", 64'(ev_cyc[i] - ev_cyc[i-1]), 2);
    check(addr_bad == 0, "R2 slot addresses", 64'(addr_bad), 0);
  endtask

  task automatic t_enable();
    logic [63:0] v;
    ring[5] = c_all(); ring[6] = c_all(); ring[7] = c_all();
    wr(3, 64'h0); ev_n = 0;
    wr(1, 64'd8); idle(20);
    rd(2, v); check(v == 5, "R5 hold while disabled", v, 5);
    check(ev_n == 0, "R5 no action while disabled", 64'(ev_n), 0);
    wr(2, 64'd6);
    rd(2, v); check(v == 6, "R12 cons write disabled", v, 6);
    wr(3, 64'h8); wait_cons(8); idle(4);
    check(ev_n == 2, "R5 resume after enable", 64'(ev_n), 2);
    wr(2, 64'd0);
    rd(2, v); check(v == 8, "R12 cons write ignored enabled", v, 8);
  endtask

  task automatic t_full();
    logic [63:0] v;
    int rc;
    for (int i = 0; i < 16; i++) ring[i] = c_asid(16'h100 + 16'(i));
    wr(3, 64'h0); wr(2, 64'd8);
    check(ring_full == 0, "R4 not full before", 64'(ring_full), 0);
    wr(1, 64'd24);
    idle(1);
    check(ring_full == 1, "R4 full flag", 64'(ring_full), 1);
    ev_n = 0;
    wr(3, 64'h8); wait_cons(24); idle(4);
    check(ev_n == 16, "R4 sixteen consumed", 64'(ev_n), 16);
    for (int i = 0; i < 16; i++)
      check(ev_arg[i] == 64'(16'h100 + 16'((i + 8) % 16)), "R3 ring order across wrap",
            ev_arg[i], 64'(16'h100 + 16'((i + 8) % 16)));
    check(ring_full == 0, "R4 full clears", 64'(ring_full), 0);
    rc = req_count; idle(10);
    check(req_count == rc, "R4 no fetch when empty", 64'(req_count), 64'(rc));
    wr(3, 64'h0); wr(2, 64'd30); wr(1, 64'd2);
    ev_n = 0;
    wr(3, 64'h8); wait_cons(2); idle(4);
    rd(2, v); check(v == 2, "R3 modulo 32", v, 2);
    check(ev_n == 4 && ev_arg[0] == 64'h10E && ev_arg[2] == 64'h100, "R3 slots 14 15 0 1",
          ev_arg[2], 64'h100);
  endtask

  task automatic t_error();
    logic [63:0] v;
    int rc;
    ring[2] = {64'b0, 56'b0, 8'h99}; ring[3] = c_all();
    ev_n = 0;
    wr(1, 64'd4); idle(10);
    check(cmd_err == 1, "R10 error flag", 64'(cmd_err), 1);
    rd(2, v); check(v == 2, "R10 cons on bad slot", v, 2);
    check(ev_n == 0, "R10 no action", 64'(ev_n), 0);
    rc = req_count; idle(8);
    check(req_count == rc, "R10 halted", 64'(req_count), 64'(rc));
    ring[2] = c_cfg(5'h0A);
    wr(3, 64'h88); wait_cons(4); idle(4);
    check(cmd_err == 0, "R10 ack clears", 64'(cmd_err), 0);
    check(ev_n == 2 && ev_kind[0] == 1 && ev_arg[0] == 64'h0A, "R10 resume at slot",
          ev_arg[0], 64'h0A);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) ring[i] = '0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_base();
    t_ops();
    t_enable();
    t_full();
    t_error();
    check(multi == 0, "R11 one action at a time", 64'(multi), 0);
    check(addr_bad == 0, "R2 all addresses", 64'(addr_bad), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule